// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block picks the winning interrupt for one eight-input interrupt controller. It receives the controller's request, in-service and mask registers together with a lowest-priority pointer, and it produces two answers: which pending, unmasked request should be raised next, and which in-service pin counts as the current highest-priority one. The second answer is the one a non-specific end-of-interrupt command would clear.

Priority rotates. The pin just after the pointer has the highest priority, and the scan wraps around through all pins. While it looks for a request, an in-service pin reached before any eligible request blocks everything at lower priority. Two mode flags relax that blocking. The special mask flag turns it off entirely. The special nested flag exempts the cascade pin only, so a second request from a chained controller can still get through.

Both answers are combinational. For test observation, a registered copy of each answer is also provided; it is one clock behind and is cleared by reset. The register storage, the bus decoding and the cascade wiring all sit outside this block.

Top module: `irq_priority_resolver`

## Requirements
- R1: The scan starts at pin (low_ptr_i + 1) modulo 8, visits all eight pins in ascending order and wraps from pin 7 to pin 0. The first qualifying pin wins.
- R2: With low_ptr_i = 7, pin 0 has the highest priority and pin 7 the lowest.
- R3: A pin can win the request search only when its req_i bit is 1 and its imr_i bit is 0.
- R4: In the request search, an in-service pin blocks when it is reached before any winner. If that pin's own request is pending, the pin still blocks rather than winning. A blocked search reports no result.
- R5: When smm_i is 1, no in-service bit blocks the request search.
- R6: When sfn_i is 1, an in-service bit on the cascade pin (pin 2) does not block. In-service bits on all other pins still block.
- R7: The in-service search returns the first pin in scan order whose isr_i bit is 1. When smm_i is 0, mask bits have no effect on this search.
- R8: When smm_i is 1, the in-service search skips any in-service pin whose imr_i bit is 1.
- R9: A search with no qualifying pin drives its valid output to 0 and its index output to 0.
- R10: The unregistered outputs follow the inputs in the same cycle. The `_q` outputs carry the value the unregistered outputs had at the previous rising clock edge, and they are 0 while rst_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the observation registers |
| rst_n | input | 1 | Active-low reset for the observation registers |
| req_i | input | 8 | Request register |
| isr_i | input | 8 | In-service register |
| imr_i | input | 8 | Mask register |
| low_ptr_i | input | 3 | Lowest-priority pin pointer |
| smm_i | input | 1 | Special mask mode flag |
| sfn_i | input | 1 | Special nested mode flag (cascade pin exempt) |
| req_valid_o | output | 1 | A request qualifies |
| req_idx_o | output | 3 | Index of the winning request |
| srv_valid_o | output | 1 | An in-service pin qualifies |
| srv_idx_o | output | 3 | Index of the highest in-service pin |
| req_valid_q_o | output | 1 | Registered req_valid_o |
| req_idx_q_o | output | 3 | Registered req_idx_o |
| srv_valid_q_o | output | 1 | Registered srv_valid_o |
| srv_idx_q_o | output | 3 | Registered srv_idx_o |

## Verification
The four unregistered results are due in the same cycle the inputs change, and the four `_q` results are due one rising edge later. The driver changes the inputs on a falling edge and queues the expected answer. The monitor waits for the next rising edge plus a small delay, then compares both sets of outputs. At that moment the unregistered outputs still reflect the stimulus, and the registered outputs have just captured it. Reset behaviour is checked on the `_q` outputs before the first stimulus.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
   localparam int unsigned DEF_PINS        = 8;
   localparam int unsigned DEF_CASCADE_PIN = 2;

   function automatic bit is_pow2(input int unsigned v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/irq_block_set.sv
module irq_block_set #(
   parameter int unsigned PINS        = irq_res_pkg::DEF_PINS,
   parameter int unsigned CASCADE_PIN = irq_res_pkg::DEF_CASCADE_PIN,
   parameter bit          NESTED_EXEMPT_EN = 1'b1
) (
   input  logic [PINS-1:0] req_i,
   input  logic [PINS-1:0] isr_i,
   input  logic [PINS-1:0] imr_i,
   input  logic            smm_i,
   input  logic            sfn_i,
   output logic [PINS-1:0] req_cand_o,
   output logic [PINS-1:0] req_stop_o,
   output logic [PINS-1:0] srv_cand_o
);
   localparam logic [PINS-1:0] CASCADE_BIT = PINS'(1) << CASCADE_PIN;

   logic [PINS-1:0] exempt;

   generate
      if (NESTED_EXEMPT_EN) begin : g_exempt
         assign exempt = sfn_i ? CASCADE_BIT : '0;
      end else begin : g_no_exempt
         logic unused_sfn;
         assign unused_sfn = sfn_i;
         assign exempt = '0;
      end
   endgenerate

   assign req_cand_o = req_i & ~imr_i;
   assign req_stop_o = smm_i ? '0 : (isr_i & ~exempt);
   assign srv_cand_o = smm_i ? (isr_i & ~imr_i) : isr_i;
endmodule

// File: rtl/irq_rot_scan.sv
module irq_rot_scan #(
   parameter int unsigned PINS = irq_res_pkg::DEF_PINS,
   localparam int unsigned IW  = $clog2(PINS)
) (
   input  logic [PINS-1:0] cand_i,
   input  logic [PINS-1:0] stop_i,
   input  logic [IW-1:0]   start_i,
   output logic            found_o,
   output logic [IW-1:0]   idx_o
);
   always_comb begin
      logic          done;
      logic [IW-1:0] pin;
      done    = 1'b0;
      found_o = 1'b0;
      idx_o   = '0;
      for (int k = 0; k < PINS; k++) begin
         pin = start_i + IW'(k);
         if (!done) begin
            if (stop_i[pin]) begin
               done = 1'b1;
            end else if (cand_i[pin]) begin
               found_o = 1'b1;
               idx_o   = pin;
               done    = 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/irq_priority_resolver.sv
module irq_priority_resolver #(
   parameter int unsigned PINS        = irq_res_pkg::DEF_PINS,
   parameter int unsigned CASCADE_PIN = irq_res_pkg::DEF_CASCADE_PIN,
   parameter bit          NESTED_EXEMPT_EN = 1'b1,
   localparam int unsigned IW = $clog2(PINS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PINS-1:0] req_i,
   input  logic [PINS-1:0] isr_i,
   input  logic [PINS-1:0] imr_i,
   input  logic [IW-1:0]   low_ptr_i,
   input  logic            smm_i,
   input  logic            sfn_i,
   output logic            req_valid_o,
   output logic [IW-1:0]   req_idx_o,
   output logic            srv_valid_o,
   output logic [IW-1:0]   srv_idx_o,
   output logic            req_valid_q_o,
   output logic [IW-1:0]   req_idx_q_o,
   output logic            srv_valid_q_o,
   output logic [IW-1:0]   srv_idx_q_o
);
   generate
      if (!irq_res_pkg::is_pow2(PINS)) begin : g_bad_pins
         $error("PINS must be a power of two and at least 2");
      end
      if (CASCADE_PIN >= PINS) begin : g_bad_cascade
         $error("CASCADE_PIN must be below PINS");
      end
   endgenerate

   logic [PINS-1:0] req_cand, req_stop, srv_cand;
   logic [IW-1:0]   start;

   assign start = low_ptr_i + IW'(1);

   irq_block_set #(
      .PINS(PINS), .CASCADE_PIN(CASCADE_PIN), .NESTED_EXEMPT_EN(NESTED_EXEMPT_EN)
   ) u_block (
      .req_i(req_i), .isr_i(isr_i), .imr_i(imr_i),
      .smm_i(smm_i), .sfn_i(sfn_i),
      .req_cand_o(req_cand), .req_stop_o(req_stop), .srv_cand_o(srv_cand)
   );

   irq_rot_scan #(.PINS(PINS)) u_req_scan (
      .cand_i(req_cand), .stop_i(req_stop), .start_i(start),
      .found_o(req_valid_o), .idx_o(req_idx_o)
   );

   irq_rot_scan #(.PINS(PINS)) u_srv_scan (
      .cand_i(srv_cand), .stop_i('0), .start_i(start),
      .found_o(srv_valid_o), .idx_o(srv_idx_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_valid_q_o <= 1'b0;
         req_idx_q_o   <= '0;
         srv_valid_q_o <= 1'b0;
         srv_idx_q_o   <= '0;
      end else begin
         req_valid_q_o <= req_valid_o;
         req_idx_q_o   <= req_idx_o;
         srv_valid_q_o <= srv_valid_o;
         srv_idx_q_o   <= srv_idx_o;
      end
   end
endmodule

// File: rtl/irq_priority_resolver_chk.sv
module irq_priority_resolver_chk #(
   parameter int unsigned PINS = irq_res_pkg::DEF_PINS,
   localparam int unsigned IW  = $clog2(PINS)
) (
   input logic            clk,
   input logic            rst_n,
   input logic [PINS-1:0] req_i,
   input logic [PINS-1:0] isr_i,
   input logic [PINS-1:0] imr_i,
   input logic            smm_i,
   input logic            req_valid_o,
   input logic [IW-1:0]   req_idx_o,
   input logic            srv_valid_o,
   input logic [IW-1:0]   srv_idx_o,
   input logic            req_valid_q_o,
   input logic            srv_valid_q_o
);
   p_winner_eligible_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o |-> (req_i[req_idx_o] && !imr_i[req_idx_o]));

   p_smm_no_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (smm_i && (|(req_i & ~imr_i))) |-> req_valid_o);

   p_srv_is_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      srv_valid_o |-> isr_i[srv_idx_o]);

   p_smm_skip_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (smm_i && srv_valid_o) |-> !imr_i[srv_idx_o]);

   p_empty_invalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!(|(req_i & ~imr_i)) && !(|isr_i)) |-> (!req_valid_o && !srv_valid_o));

   p_reg_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((req_valid_q_o == $past(req_valid_o)) &&
                (srv_valid_q_o == $past(srv_valid_o))));
endmodule

bind irq_priority_resolver irq_priority_resolver_chk #(.PINS(PINS)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_i(req_i), .isr_i(isr_i), .imr_i(imr_i),
   .smm_i(smm_i), .req_valid_o(req_valid_o), .req_idx_o(req_idx_o),
   .srv_valid_o(srv_valid_o), .srv_idx_o(srv_idx_o),
   .req_valid_q_o(req_valid_q_o), .srv_valid_q_o(srv_valid_q_o)
);

// File: tb/irq_priority_resolver_bench.sv
module irq_priority_resolver_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] req = '0, isr = '0, imr = '0;
   logic [2:0] ptr = 3'd7;
   logic       smm = 1'b0, sfn = 1'b0;
   logic       rv, sv, rvq, svq;
   logic [2:0] ri, si, riq, siq;

   int checks = 0;
   int errors = 0;
   bit drv_done = 1'b0;

   typedef struct {
      logic       rv;
      logic [2:0] ri;
      logic       sv;
      logic [2:0] si;
      string      tag;
   } exp_t;
   exp_t sb[$];

   always #4 clk = ~clk;

   irq_priority_resolver u_irq_priority_resolver (
      .clk(clk), .rst_n(rst_n), .req_i(req), .isr_i(isr), .imr_i(imr),
      .low_ptr_i(ptr), .smm_i(smm), .sfn_i(sfn),
      .req_valid_o(rv), .req_idx_o(ri), .srv_valid_o(sv), .srv_idx_o(si),
      .req_valid_q_o(rvq), .req_idx_q_o(riq),
      .srv_valid_q_o(svq), .srv_idx_q_o(siq)
   );

   task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Reference model written from the requirements
   function automatic exp_t model(input logic [7:0] q, input logic [7:0] s,
                                  input logic [7:0] m, input logic [2:0] p,
                                  input logic sm, input logic sf, input string tag);
      exp_t e;
      logic [7:0] blk;
      bit stop;
      e.rv = 0; e.ri = 0; e.sv = 0; e.si = 0; e.tag = tag;
      blk = sm ? 8'h00 : (s & (sf ? 8'hFB : 8'hFF));
      stop = 0;
      for (int k = 0; k < 8; k++) begin
         logic [2:0] pin;
         pin = p + 3'd1 + 3'(k);
         if (!stop) begin
            if (blk[pin]) stop = 1;
            else if (q[pin] && !m[pin]) begin e.rv = 1; e.ri = pin; stop = 1; end
         end
      end
      stop = 0;
      for (int k = 0; k < 8; k++) begin
         logic [2:0] pin;
         pin = p + 3'd1 + 3'(k);
         if (!stop && s[pin] && !(sm && m[pin])) begin e.sv = 1; e.si = pin; stop = 1; end
      end
      return e;
   endfunction

   task automatic drive(input logic [2:0] p, input logic [7:0] q, input logic [7:0] s,
                        input logic [7:0] m, input logic sm, input logic sf,
                        input string tag);
      @(negedge clk);
      ptr = p; req = q; isr = s; imr = m; smm = sm; sfn = sf;
      sb.push_back(model(q, s, m, p, sm, sf, tag));
   endtask

   // Monitor: combinational results due now, registered copies latched at this edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check({e.tag, " req"},   {rv, ri},   {e.rv, e.ri});
            check({e.tag, " srv"},   {sv, si},   {e.sv, e.si});
            check({e.tag, " R10 req_q"}, {rvq, riq}, {e.rv, e.ri});
            check({e.tag, " R10 srv_q"}, {svq, siq}, {e.sv, e.si});
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R10 reset req_q", {rvq, riq}, 4'h0);
      check("R10 reset srv_q", {svq, siq}, 4'h0);
      @(negedge clk);
      rst_n = 1'b1;
      drive(3'd7, 8'hA4, 8'h00, 8'h00, 0, 0, "R2 fixed order");
      drive(3'd3, 8'h11, 8'h00, 8'h00, 0, 0, "R1 rotated start");
      drive(3'd6, 8'h41, 8'h00, 8'h00, 0, 0, "R1 wrap");
      drive(3'd7, 8'h06, 8'h00, 8'h02, 0, 0, "R3 masked skip");
      drive(3'd7, 8'h20, 8'h08, 8'h00, 0, 0, "R4 isr blocks");
      drive(3'd7, 8'h08, 8'h08, 8'h00, 0, 0, "R4 same pin blocks");
      drive(3'd7, 8'h02, 8'h08, 8'h00, 0, 0, "R4 higher passes");
      drive(3'd7, 8'h20, 8'h08, 8'h00, 1, 0, "R5 smm lifts block");
      drive(3'd7, 8'h10, 8'h04, 8'h00, 0, 1, "R6 cascade exempt");
      drive(3'd7, 8'h10, 8'h04, 8'h00, 0, 0, "R6 cascade blocks w/o flag");
      drive(3'd7, 8'h10, 8'h02, 8'h00, 0, 1, "R6 other pin blocks");
      drive(3'd5, 8'h00, 8'h90, 8'h80, 0, 0, "R7 mask ignored");
      drive(3'd5, 8'h00, 8'h90, 8'h80, 1, 0, "R8 smm skips masked");
      drive(3'd0, 8'h00, 8'h00, 8'h00, 0, 0, "R9 nothing pending");
      drive(3'd2, 8'hFF, 8'h00, 8'hFF, 1, 1, "R9 all masked");
      @(negedge clk);
      req = '0; isr = '0; imr = '0;
      repeat (3) @(posedge clk);
      drv_done = 1'b1;
   end

   initial begin
      fork
         wait (drv_done);
         begin
            repeat (2000) @(posedge clk);
            errors++;
            $display("FAIL watchdog: actual hung expected done");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule